// File: doc/BRIEF.md
# Arbitrated Short Bus Reset Requester

This block turns a one-shot software request into a persistent request for a short bus reset. The short reset is won through arbitration. A register write of 1 to the request bit is accepted only when no port is entering suspend or resume. When the write is accepted, the block tells the arbitration logic to drop any fair request it holds. It then waits for a sub-action gap and raises its arbitration request.

If arbitration is lost, the block waits for the next gap and tries again. It keeps doing so for as long as the request is pending. When the request is granted, the block starts a short bus reset. If a cycle-count time-out expires first, it starts a long bus reset instead.

The request bit has no stored read value and always reads back as 0. The line signalling on the cable belongs to the arbitration and reset logic around this block.

Top module: `arb_short_reset_req`

## Requirements
- R1: From idle, a write strobe carrying a data bit of 1 while no port is busy starts a pending request, and `fair_cancel` is high for exactly the one cycle after the write.
- R2: A write of 1 while any bit of `port_busy` is set is ignored: no `fair_cancel`, and later gaps raise no `arb_req`.
- R3: A write strobe carrying a data bit of 0 is ignored.
- R4: `arb_req` rises only in the cycle after `gap_seen` was sampled high while a request was pending. It stays high until grant, loss or time-out. A gap while idle has no effect.
- R5: A lost arbitration (`arb_lost` without `arb_grant`) drops `arb_req` in the next cycle while keeping the request pending. The next gap raises `arb_req` again.
- R6: A grant while `arb_req` is high gives a `short_rst_start` pulse of exactly one cycle in the next cycle, after which the block is idle.
- R7: If no grant arrives, `long_rst_start` pulses for one cycle exactly TIMEOUT_CYC cycles after the `fair_cancel` cycle. A grant sampled on the expiry edge takes precedence and gives a short reset instead.
- R8: A further write of 1 while a request is pending has no effect: it gives no new `fair_cancel` and does not restart the time-out.
- R9: `rd_data`, the read value of the request bit, is always 0.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe covering the request bit |
| wr_data | input | 1 | Value written to the request bit |
| port_busy | input | NPORTS | Per-port flag: suspend or resume entry in progress |
| gap_seen | input | 1 | Sub-action gap detected |
| arb_grant | input | 1 | Arbitration won |
| arb_lost | input | 1 | Arbitration lost |
| rd_data | output | 1 | Read value of the request bit (always 0) |
| arb_req | output | 1 | Arbitration request for the short reset |
| short_rst_start | output | 1 | One-cycle start of a short bus reset |
| long_rst_start | output | 1 | One-cycle start of a long bus reset |
| fair_cancel | output | 1 | One-cycle order to abandon a pending fair request |

## Verification
The bench targets the points where a simplified design would drift from the requirements.

- **Busy ports and zero writes.** A write made while a single port is busy, or a write of 0, must leave the block idle. A design that ignored `port_busy` would pulse `fair_cancel` and later arbitrate.
- **Lost arbitration.** After a loss the request must survive until the next gap. A design that treated the request like a fair one would fall back to idle and never reset the bus.
- **Time-out window.** This is checked to the exact cycle. A design whose counter was restarted by a repeated write would pulse `long_rst_start` late.
- **Grant on the expiry edge.** A grant that lands on the same edge as the expiry must still give a short reset. A design with the wrong priority would pulse `long_rst_start` instead.

// File: rtl/arb_short_reset_pkg.sv
package arb_short_reset_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP   = 3'd1,
    ST_ARB   = 3'd2,
    ST_SHORT = 3'd3,
    ST_LONG  = 3'd4
  } rq_state_t;
endpackage

// File: rtl/rq_accept.sv
// Decides whether a software write becomes a new request.
module rq_accept #(
  parameter int NPORTS = 4
) (
  input  logic              idle,
  input  logic              wr_en,
  input  logic              wr_data,
  input  logic [NPORTS-1:0] port_busy,
  output logic              accept
);
  logic any_busy;

  always_comb begin
    any_busy = |port_busy;
    accept   = idle && wr_en && wr_data && !any_busy;
  end
endmodule

// File: rtl/rq_timer.sv
// Counts cycles while a request is pending; flags expiry on the last one.
module rq_timer #(
  parameter int TIMEOUT_CYC = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_comb expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (start)           cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rq_fsm.sv
// Sequencer: gap wait, arbitration, retries and reset start, with registered outputs.
module rq_fsm
  import arb_short_reset_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic gap_seen,
  input  logic arb_grant,
  input  logic arb_lost,
  input  logic expired,
  output logic idle,
  output logic pending,
  output logic arb_req,
  output logic short_rst_start,
  output logic long_rst_start,
  output logic fair_cancel
);
  rq_state_t st, nx;

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE: if (accept) nx = ST_GAP;
      ST_GAP: begin
        if (expired)       nx = ST_LONG;
        else if (gap_seen) nx = ST_ARB;
      end
      ST_ARB: begin
        if (arb_grant)     nx = ST_SHORT;
        else if (expired)  nx = ST_LONG;
        else if (arb_lost) nx = ST_GAP;
      end
      ST_SHORT: nx = ST_IDLE;
      ST_LONG:  nx = ST_IDLE;
      default:  nx = ST_IDLE;
    endcase
  end

  always_comb begin
    idle    = (st == ST_IDLE);
    pending = (st == ST_GAP) || (st == ST_ARB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st              <= ST_IDLE;
      arb_req         <= 1'b0;
      short_rst_start <= 1'b0;
      long_rst_start  <= 1'b0;
      fair_cancel     <= 1'b0;
    end else begin
      st              <= nx;
      arb_req         <= (nx == ST_ARB);
      short_rst_start <= (nx == ST_SHORT);
      long_rst_start  <= (nx == ST_LONG);
      fair_cancel     <= accept;
    end
  end
endmodule

// File: rtl/arb_short_reset_req.sv
module arb_short_reset_req #(
  parameter int NPORTS      = 4,
  parameter int TIMEOUT_CYC = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_data,
  input  logic [NPORTS-1:0] port_busy,
  input  logic              gap_seen,
  input  logic              arb_grant,
  input  logic              arb_lost,
  output logic              rd_data,
  output logic              arb_req,
  output logic              short_rst_start,
  output logic              long_rst_start,
  output logic              fair_cancel
);
  logic idle, pending, accept, expired;

  // The request bit holds no state visible to software.
  assign rd_data = 1'b0;

  rq_accept #(.NPORTS(NPORTS)) u_accept (
    .idle(idle), .wr_en(wr_en), .wr_data(wr_data),
    .port_busy(port_busy), .accept(accept)
  );

  rq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .run(pending), .expired(expired)
  );

  rq_fsm u_fsm (
    .clk(clk), .rst(rst), .accept(accept), .gap_seen(gap_seen),
    .arb_grant(arb_grant), .arb_lost(arb_lost), .expired(expired),
    .idle(idle), .pending(pending), .arb_req(arb_req),
    .short_rst_start(short_rst_start), .long_rst_start(long_rst_start),
    .fair_cancel(fair_cancel)
  );
endmodule

// File: rtl/arb_short_reset_req_chk.sv
module arb_short_reset_req_chk #(
  parameter int NPORTS      = 4,
  parameter int TIMEOUT_CYC = 30000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_data,
  input logic [NPORTS-1:0] port_busy,
  input logic              gap_seen,
  input logic              arb_grant,
  input logic              arb_lost,
  input logic              arb_req,
  input logic              short_rst_start,
  input logic              long_rst_start,
  input logic              fair_cancel
);
  logic pend_q;
  int   wait_k;
  logic idle_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      wait_k <= 0;
    end else begin
      if (short_rst_start || long_rst_start) pend_q <= 1'b0;
      else if (fair_cancel)                  pend_q <= 1'b1;

      if (fair_cancel) wait_k <= 1;
      else if (pend_q) wait_k <= wait_k + 1;
    end
  end

  always_comb
    idle_c = !pend_q && !fair_cancel && !short_rst_start && !long_rst_start;

  a_r1_accept: assert property (@(posedge clk) disable iff (rst)
    (idle_c && wr_en && wr_data && !(|port_busy)) |=> fair_cancel);
  a_r1_cancel_once: assert property (@(posedge clk) disable iff (rst)
    fair_cancel |=> !fair_cancel);
  a_r2_busy_block: assert property (@(posedge clk) disable iff (rst)
    (idle_c && wr_en && |port_busy) |=> !fair_cancel);
  a_r3_zero_write: assert property (@(posedge clk) disable iff (rst)
    (idle_c && wr_en && !wr_data) |=> !fair_cancel);
  a_r4_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_req) |-> $past(gap_seen));
  a_r4_idle_gap: assert property (@(posedge clk) disable iff (rst)
    (idle_c && gap_seen) |=> !arb_req);
  a_r5_lost_retry: assert property (@(posedge clk) disable iff (rst)
    (arb_req && arb_lost && !arb_grant) |=> (!arb_req && !short_rst_start));
  a_r6_grant: assert property (@(posedge clk) disable iff (rst)
    (arb_req && arb_grant) |=> (short_rst_start && !long_rst_start));
  a_r6_short_pulse: assert property (@(posedge clk) disable iff (rst)
    short_rst_start |=> !short_rst_start);
  a_r7_long_pulse: assert property (@(posedge clk) disable iff (rst)
    long_rst_start |=> !long_rst_start);
  a_r7_window: assert property (@(posedge clk) disable iff (rst)
    long_rst_start |-> (wait_k == TIMEOUT_CYC));
  a_r8_no_recancel: assert property (@(posedge clk) disable iff (rst)
    (pend_q && wr_en) |=> !fair_cancel);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arb_req, short_rst_start, long_rst_start}));
endmodule

bind arb_short_reset_req arb_short_reset_req_chk #(
  .NPORTS(NPORTS), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .port_busy(port_busy), .gap_seen(gap_seen), .arb_grant(arb_grant),
  .arb_lost(arb_lost), .arb_req(arb_req), .short_rst_start(short_rst_start),
  .long_rst_start(long_rst_start), .fair_cancel(fair_cancel)
);

// File: tb/arb_short_reset_req_bench.sv
module arb_short_reset_req_bench;
  localparam int NP = 4;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_data = 1'b0, gap_seen = 1'b0, arb_grant = 1'b0, arb_lost = 1'b0;
  logic [NP-1:0] port_busy = '0;
  logic rd_data, arb_req, short_rst_start, long_rst_start, fair_cancel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  arb_short_reset_req #(.NPORTS(NP), .TIMEOUT_CYC(TO)) u_arb_short_reset_req (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .port_busy(port_busy), .gap_seen(gap_seen), .arb_grant(arb_grant),
    .arb_lost(arb_lost), .rd_data(rd_data), .arb_req(arb_req),
    .short_rst_start(short_rst_start), .long_rst_start(long_rst_start),
    .fair_cancel(fair_cancel)
  );

  // Row layout: [16:13] requirement, [12] wr_en, [11] wr_data, [10:7] port_busy,
  // [6] gap, [5] grant, [4] lost, [3:0] expected {arb_req, short, long, cancel}
  localparam int NROW = 16;
  localparam logic [16:0] TBL [NROW] = '{
    {4'd10, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd3,  1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd4,  1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'b0000},
    {4'd2,  1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd2,  1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'b0000},
    {4'd1,  1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0001},
    {4'd1,  1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd8,  1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd4,  1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'b1000},
    {4'd4,  1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b1000},
    {4'd5,  1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'b0000},
    {4'd5,  1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd5,  1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'b1000},
    {4'd6,  1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'b0100},
    {4'd6,  1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd6,  1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'b0000}
  };

  function automatic string rname(input logic [3:0] idx);
    case (idx)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [3:0] outs();
    return {arb_req, short_rst_start, long_rst_start, fair_cancel};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_data = 1'b0; port_busy = '0;
    gap_seen = 1'b0; arb_grant = 1'b0; arb_lost = 1'b0;
  endtask

  // Accept a request; on return the fair_cancel cycle is current.
  task automatic do_accept();
    wr_en = 1'b1; wr_data = 1'b1; tick(); idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: outputs held low during and after reset
    repeat (3) tick();
    check("R10", outs(), 4'b0000);
    rst = 1'b0;
    tick();
    check("R10", outs(), 4'b0000);
    check("R9", {3'b000, rd_data}, 4'b0000);

    for (int i = 0; i < NROW; i++) begin
      wr_en     = TBL[i][12];
      wr_data   = TBL[i][11];
      port_busy = TBL[i][10:7];
      gap_seen  = TBL[i][6];
      arb_grant = TBL[i][5];
      arb_lost  = TBL[i][4];
      tick();
      check(rname(TBL[i][16:13]), outs(), TBL[i][3:0]);
      check("R9", {3'b000, rd_data}, 4'b0000);
    end
    idle_inputs();
    tick();

    // R7: time-out with no gap ever seen
    do_accept();
    check("R1", outs(), 4'b0001);
    for (int k = 1; k < TO; k++) begin
      tick();
      check("R7", outs(), 4'b0000);
    end
    tick();
    check("R7", outs(), 4'b0010);
    tick();
    check("R7", outs(), 4'b0000);

    // R8: repeated write mid-way must not restart the time-out
    do_accept();
    for (int k = 1; k < TO; k++) begin
      if (k == 6) begin wr_en = 1'b1; wr_data = 1'b1; end
      tick();
      idle_inputs();
      check("R8", outs(), 4'b0000);
    end
    tick();
    check("R8", outs(), 4'b0010);

    // R7: grant sampled on the expiry edge wins over the time-out
    tick();
    do_accept();
    gap_seen = 1'b1;
    tick();
    gap_seen = 1'b0;
    check("R4", outs(), 4'b1000);
    for (int k = 2; k < TO; k++) tick();
    check("R7", outs(), 4'b1000);
    arb_grant = 1'b1;
    tick();
    arb_grant = 1'b0;
    check("R7", outs(), 4'b0100);
    tick();
    check("R6", outs(), 4'b0000);

    // R2: busy on the highest port blocks a write
    port_busy = 4'h8; wr_en = 1'b1; wr_data = 1'b1;
    tick();
    idle_inputs();
    check("R2", outs(), 4'b0000);
    gap_seen = 1'b1;
    tick();
    gap_seen = 1'b0;
    check("R2", outs(), 4'b0000);
    check("R9", {3'b000, rd_data}, 4'b0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule